// File: doc/BRIEF.md
# Periodic-Reload Down-Counter Motor PWM

This block turns an 8-bit captured servo-pulse code into a motor drive PWM wave whose duty cycle spans the full 0% to 100% range. A prescaler, whose divide ratio is a power of two chosen by a 3-bit rate select, produces a decrement tick. A 7-bit phase counter groups 128 ticks into one PWM period and issues a single-cycle reload strobe on the last tick of each period. At that strobe a level counter is loaded from the low seven bits of the code. On every later tick it counts down, and it stops at zero. The output is high while the level is nonzero.

The most significant code bit acts as a reload gate. When it is clear, no load happens, the level drains to zero, and the output stays off. This maps short receiver pulses to a fully off motor. A code with all seven low bits set is loaded as a full 128, so the output never drops for even one tick. The PWM timing runs on its own schedule, independent of the receiver frames. The code and the rate select are both sampled only at the reload strobe. A true output and a complementary output are provided.

Top module: `motor_pwm_reload`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, `pwm_o` is 0 and `pwm_n_o` is 1.
- R2: With rate select value s, one decrement tick occurs every 2^s clocks, and one PWM period is 128 ticks (128·2^s clocks).
- R3: When code bit 7 is 1 and code[6:0] = N with N < 127, the output is high for exactly N ticks of each period and low for the other 128−N ticks. For example, 0xA0 gives 32/128 and 0xC0 gives 64/128.
- R4: Code 0xFF keeps the output high continuously, which is 100% duty with no low tick.
- R5: When code bit 7 is 0, no reload takes place and the output stays low for the whole period.
- R6: A change of the code between reload strobes has no effect on the output until the next strobe.
- R7: The rate select is sampled only at the reload strobe. A change between strobes does not alter the tick spacing of the period in progress.
- R8: `pwm_n_o` is always the complement of `pwm_o`.
- R9: Counting down halts at zero and never wraps. Code 0x80 therefore gives a constantly low output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 8 | Captured pulse-width code |
| rate_sel_i | input | 3 | Prescaler tap select, one tick every 2^value clocks |
| pwm_o | output | 1 | PWM drive output |
| pwm_n_o | output | 1 | Complementary PWM drive output |

## Verification
The bench targets the boundaries of the code range. For 0xFF, a design without the full-scale adjustment would emit a one-tick low glitch every period. For 0x80, a counter that wraps below zero would turn fully on. For codes below 0x80, a design that ignored the reload gate would still produce duty. The bench also changes the code and the rate select in the middle of a period, where a design that sampled them continuously would truncate or stretch that period. A cycle-by-cycle reference model catches any such deviation on the clock where it first occurs.

// File: rtl/pwmr_pkg.sv
package pwmr_pkg;

    localparam int PHASE_W = 7;
    localparam int SEL_W   = 3;

    // Timing pulses passed from the prescaler and phase counter
    typedef struct packed {
        logic tick;
        logic strobe;
    } pwmr_timing_t;

    // Full-scale adjusted load value: all-ones fraction maps to 2**phase_w
    function automatic int pwmr_load(input int frac, input int phase_w);
        if (frac == (1 << phase_w) - 1)
            return 1 << phase_w;
        return frac;
    endfunction

    // Terminal count of the prescaler for a given tap select
    function automatic int pwmr_limit(input int sel);
        return (1 << sel) - 1;
    endfunction

endpackage

// File: rtl/pwmr_prescale.sv
module pwmr_prescale
    import pwmr_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] rate_sel_i,
    input  logic          strobe_i,
    output logic          tick_o
);
    localparam int PW = (1 << SW) - 1;

    logic [SW-1:0] rate_q;
    logic [PW-1:0] pre_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit  = PW'(pwmr_limit(int'(rate_q)));
        tick_o = (pre_q == limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            rate_q <= '0;
        end else begin
            if (tick_o) pre_q <= '0;
            else        pre_q <= pre_q + 1'b1;
            if (strobe_i) rate_q <= rate_sel_i;
        end
    end

    // R7: rate select only taken at the period boundary
    a_r7_rate_hold: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> $stable(rate_q));

    // R2: prescaler never passes its terminal count
    a_r2_pre_bound: assert property (@(posedge clk) disable iff (rst)
        pre_q <= limit);

endmodule

// File: rtl/pwmr_phase.sv
module pwmr_phase
    import pwmr_pkg::*;
#(
    parameter int PHW = PHASE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic strobe_o
);
    logic [PHW-1:0] phase_q;

    always_comb strobe_o = tick_i && (phase_q == {PHW{1'b1}});

    always_ff @(posedge clk) begin
        if (rst)         phase_q <= '0;
        else if (tick_i) phase_q <= phase_q + 1'b1;
    end

    // R2: the strobe closes a period and the phase restarts at zero
    a_r2_strobe_wrap: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> (phase_q == '0));

    a_r2_phase_idle: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(phase_q));

endmodule

// File: rtl/pwmr_level.sv
module pwmr_level
    import pwmr_pkg::*;
#(
    parameter int PHW = PHASE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  pwmr_timing_t tim_i,
    input  logic [PHW:0] code_i,
    output logic         active_o
);
    localparam int CW = PHW + 1;

    logic [CW-1:0] lvl_q;
    logic          do_load;
    logic [CW-1:0] load_val;

    always_comb begin
        do_load  = tim_i.tick && tim_i.strobe && code_i[PHW];
        load_val = CW'(pwmr_load(int'(code_i[PHW-1:0]), PHW));
        active_o = (lvl_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
        end else if (do_load) begin
            lvl_q <= load_val;
        end else if (tim_i.tick && lvl_q != '0) begin
            lvl_q <= lvl_q - 1'b1;
        end
    end

    // R9: count halts at zero
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (tim_i.tick && !do_load && lvl_q == '0) |=> (lvl_q == '0));

    // R3: one step down per tick between loads
    a_r3_one_step: assert property (@(posedge clk) disable iff (rst)
        (tim_i.tick && !do_load && lvl_q != '0) |=> (lvl_q == $past(lvl_q) - 1'b1));

    // R5: a clear gate bit blocks the reload
    a_r5_gate_off: assert property (@(posedge clk) disable iff (rst)
        (tim_i.strobe && !code_i[PHW] && lvl_q == '0) |=> (lvl_q == '0));

    // R3: level never exceeds one full period
    a_r3_max_level: assert property (@(posedge clk) disable iff (rst)
        lvl_q <= CW'(1 << PHW));

    // R6: level only moves on ticks
    a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
        !tim_i.tick |=> $stable(lvl_q));

endmodule

// File: rtl/motor_pwm_reload.sv
module motor_pwm_reload
    import pwmr_pkg::*;
#(
    parameter int PHW = PHASE_W,
    parameter int SW  = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PHW:0]  code_i,
    input  logic [SW-1:0] rate_sel_i,
    output logic          pwm_o,
    output logic          pwm_n_o
);
    pwmr_timing_t tim;
    logic         active;

    pwmr_prescale #(.SW(SW)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .rate_sel_i(rate_sel_i),
        .strobe_i  (tim.strobe),
        .tick_o    (tim.tick)
    );

    pwmr_phase #(.PHW(PHW)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tim.tick),
        .strobe_o(tim.strobe)
    );

    pwmr_level #(.PHW(PHW)) u_level (
        .clk     (clk),
        .rst     (rst),
        .tim_i   (tim),
        .code_i  (code_i),
        .active_o(active)
    );

    always_comb begin
        pwm_o   = active;
        pwm_n_o = !active;
    end

    // R1: output off right after reset
    a_r1_reset_off: assert property (@(posedge clk)
        $past(rst) |-> !pwm_o);

    // R4/R6: output only changes on a tick
    a_r6_edge_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tim.tick |=> $stable(pwm_o));

endmodule

// File: tb/motor_pwm_reload_bench.sv
module motor_pwm_reload_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] code = 8'h00;
    logic [2:0] sel = 3'd0;
    logic       pwm, pwm_n;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;
    string tag = "R1";

    // Reference model state
    int m_div = 0, m_rate = 0, m_phase = 0, m_lvl = 0;

    always #2.5 clk = ~clk;

    motor_pwm_reload u_motor_pwm_reload (
        .clk(clk), .rst(rst), .code_i(code), .rate_sel_i(sel),
        .pwm_o(pwm), .pwm_n_o(pwm_n)
    );

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            m_div = 0; m_rate = 0; m_phase = 0; m_lvl = 0;
        end else begin
            m_div = m_div + 1;
            if (m_div == (1 << m_rate)) begin
                m_div = 0;
                if (m_phase == 127) begin
                    m_phase = 0;
                    m_rate = sel;
                    if (code >= 128)
                        m_lvl = (code % 128 == 127) ? 128 : code % 128;
                    else if (m_lvl > 0)
                        m_lvl = m_lvl - 1;
                end else begin
                    m_phase = m_phase + 1;
                    if (m_lvl > 0) m_lvl = m_lvl - 1;
                end
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (pwm !== (m_lvl != 0)) begin
                errors++;
                $display("FAIL %s: pwm_o=%0b expected %0b at %0t", tag, pwm, (m_lvl != 0), $time);
            end
            checks++;
            if (pwm_n !== ~pwm) begin
                errors++;
                $display("FAIL R8: pwm_n_o=%0b expected %0b at %0t", pwm_n, ~pwm, $time);
            end
        end
    end

    task automatic settle(input int cyc);
        repeat (cyc) @(negedge clk);
    endtask

    // Measure high clocks over one steady-state period and compare
    task automatic duty(input logic [7:0] c, input logic [2:0] s, input int exp_ticks, input string t);
        int hi = 0;
        int per;
        @(negedge clk);
        code = c; sel = s; tag = t;
        per = 128 * (1 << s);
        settle(3 * 128 * 4);
        for (int i = 0; i < per; i++) begin
            @(negedge clk);
            if (pwm) hi++;
        end
        checks++;
        if (hi != exp_ticks * (1 << s)) begin
            errors++;
            $display("FAIL %s: high clocks=%0d expected %0d (code %h sel %0d)", t, hi, exp_ticks * (1 << s), c, s);
        end
    endtask

    initial begin
        // R1: reset state
        settle(4);
        checks++;
        if (pwm !== 1'b0 || pwm_n !== 1'b1) begin
            errors++;
            $display("FAIL R1: pwm=%0b pwm_n=%0b expected 0/1", pwm, pwm_n);
        end
        rst = 1'b0;
        code = 8'hA0;
        settle(100);
        checks++;
        if (pwm !== 1'b0) begin
            errors++;
            $display("FAIL R1: pwm=%0b expected 0 before first load", pwm);
        end

        duty(8'hA0, 3'd0, 32,  "R3");
        duty(8'hC0, 3'd0, 64,  "R3");
        duty(8'hFF, 3'd0, 128, "R4");
        duty(8'h7F, 3'd0, 0,   "R5");
        duty(8'h3A, 3'd1, 0,   "R5");
        duty(8'h80, 3'd0, 0,   "R9");
        duty(8'h81, 3'd2, 1,   "R2");
        duty(8'hFE, 3'd1, 126, "R3");

        // R6: code churned mid-period, model checks every cycle
        tag = "R6";
        sel = 3'd0;
        for (int k = 0; k < 40; k++) begin
            settle(37);
            code = 8'(k * 53 + 17);
        end

        // R7: rate select churned mid-period
        tag = "R7";
        code = 8'hB0;
        for (int k = 0; k < 20; k++) begin
            settle(97);
            sel = 3'(k % 3);
        end
        settle(1600);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule